// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the control side of a flash-style memory that answers synchronous burst reads. A configuration word sets three things: how many clocks pass between the burst request and the first data word, whether the active-low wait indicator ends together with that delay or one clock before it, and how many bytes one burst moves. A start request carries a word address. The block first counts out the programmed delay while it holds the wait indicator low. It then presents one word address per clock, with a valid strobe, until the burst is complete. A single-cycle completion pulse follows, and the block returns to idle.

The host bus is 16 or 32 bits wide, and the sequencer sizes the burst to match. The addresses step linearly and wrap inside the aligned window that one burst covers, so a request into the middle of a line returns the whole line. Several size codes, and some code and bus-width pairs, permit no burst. For those settings start requests get no response, and reads must use the asynchronous path, which lies outside this block. The memory array sits outside the block and is addressed through `mem_addr`.

Top module: `burst_read_seq`

## Requirements
- R1: After reset, `cfg_rdata` reads 16'h1CC4, `wait_n` is 1, and `data_valid` and `done` are 0.
- R2: `cfg_rdata` returns the written bits 13..10 (delay code), bit 8 (early-wait mode) and bits 2..0 (size code). Bits 7 and 6 always read 1. Every other bit, including bits 9 and 5..3, reads 0.
- R3: The delay code selects a latency of L = code + 2 clocks for codes 0..7 and 9 clocks for codes 8..15. If the rising edge that accepts a start is edge 0, `data_valid` is first high after edge L.
- R4: With bit 8 = 0, `wait_n` is 0 in all L delay cycles and 1 from the first data cycle onward. It is 1 whenever the block is idle.
- R5: With bit 8 = 1, `wait_n` is 0 for the first L-1 delay cycles only and returns to 1 in the last delay cycle.
- R6: The size code gives 8 bytes (1), 16 (2), 32 (3) or 64 (4). A burst presents bytes/2 words when `bus_x32`=0 and bytes/4 words when `bus_x32`=1. `data_valid` is high for exactly that many consecutive cycles.
- R7: Size codes 0, 5, 6 and 7 never start a burst, and neither does code 4 with `bus_x32`=1. A start under these settings leaves `wait_n` at 1 and `data_valid` and `done` at 0.
- R8: Data word i of a burst of N words from start address A has address (A with its low log2 N bits cleared) + ((A mod N) + i) mod N.
- R9: `done` is high for exactly one cycle, the cycle right after the last valid word.
- R10: A start is accepted only while idle. A start raised during the delay, the data or the `done` cycle is ignored, and the block is idle with no data in the cycle after `done`.
- R11: A configuration write takes effect only while idle and is ignored otherwise. A burst uses the configuration that held before the edge that accepted it, so a write in the same cycle as a start applies from the following burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word to write |
| cfg_rdata | output | 16 | Current configuration word |
| bus_x32 | input | 1 | 1 = 32-bit host bus, 0 = 16-bit |
| start | input | 1 | Burst request |
| start_addr | input | ADDR_W | Word address of the first requested word |
| wait_n | output | 1 | Active-low wait indicator |
| mem_addr | output | ADDR_W | Word address presented to the array |
| data_valid | output | 1 | The word at `mem_addr` is being delivered this cycle |
| done | output | 1 | One-cycle pulse after the last word |

## Verification
Two pairs of events can land in the same cycle. A configuration write can arrive on the same edge as an accepted start, and a new start can arrive in the `done` cycle. The bench raises the write and the start together, then measures the latency of that burst and of the next burst, expecting the old and then the new delay. In every second burst of the full sweep over delay, wait mode, size code and bus width, it also holds `start` high during the `done` cycle and drives a write in mid-burst. It then checks that the cycle after `done` is idle and that the configuration word is unchanged.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_DATA  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic [3:0] lat;
    logic       early_wait;
    logic [2:0] blen;
  } seq_cfg_t;

  localparam seq_cfg_t CFG_DEFAULT = '{lat: 4'd7, early_wait: 1'b0, blen: 3'd4};

  // Delay in clocks; codes with the top bit set saturate at the longest delay.
  function automatic logic [3:0] lat_clocks(input logic [3:0] code);
    return code[3] ? 4'd9 : 4'(code + 4'd2);
  endfunction

  function automatic logic burst_enabled(input logic [2:0] blen, input logic x32);
    return ((blen >= 3'd1) && (blen <= 3'd3)) || ((blen == 3'd4) && !x32);
  endfunction

  // log2 of the word count: bytes = 4 << blen, word = 2 or 4 bytes.
  function automatic logic [2:0] words_log2(input logic [2:0] blen, input logic x32);
    return 3'(blen + 3'd1 - {2'b00, x32});
  endfunction

  function automatic logic [15:0] cfg_to_word(input seq_cfg_t c);
    logic [15:0] w;
    w        = '0;
    w[13:10] = c.lat;
    w[8]     = c.early_wait;
    w[7:6]   = 2'b11;
    w[2:0]   = c.blen;
    return w;
  endfunction

  function automatic seq_cfg_t cfg_from_word(input logic [15:0] w);
    seq_cfg_t c;
    c.lat        = w[13:10];
    c.early_wait = w[8];
    c.blen       = w[2:0];
    return c;
  endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        idle,
  input  logic [15:0] wdata,
  output seq_cfg_t    cfg,
  output logic [15:0] rdata
);

  logic wr_take;
  assign wr_take = wr_en && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_DEFAULT;
    end else if (wr_take) begin
      cfg <= cfg_from_word(wdata);
    end
  end

  assign rdata = cfg_to_word(cfg);

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int WC_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       x32,
  input  seq_cfg_t   cfg_live,
  output seq_state_t state,
  output logic       idle,
  output logic       start_accept,
  output logic       last_word,
  output logic [2:0] act_wlog,
  output logic       wait_n,
  output logic       data_valid,
  output logic       done
);

  logic [3:0]      dly_cnt;
  logic [WC_W-1:0] word_cnt;
  logic [WC_W-1:0] words_m1;
  logic            act_early;
  logic            delay_end;
  logic [WC_W-1:0] ones;

  assign ones         = '1;
  assign idle         = (state == ST_IDLE);
  assign start_accept = start && idle && burst_enabled(cfg_live.blen, x32);
  assign words_m1     = ~(ones << act_wlog);
  assign delay_end    = (state == ST_DELAY) && (dly_cnt == 4'd0);
  assign last_word    = (state == ST_DATA) && (word_cnt == words_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dly_cnt   <= '0;
      word_cnt  <= '0;
      act_early <= 1'b0;
      act_wlog  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_accept) begin
            state     <= ST_DELAY;
            dly_cnt   <= 4'(lat_clocks(cfg_live.lat) - 4'd1);
            act_early <= cfg_live.early_wait;
            act_wlog  <= words_log2(cfg_live.blen, x32);
          end
        end
        ST_DELAY: begin
          if (delay_end) begin
            state    <= ST_DATA;
            word_cnt <= '0;
          end else begin
            dly_cnt <= dly_cnt - 4'd1;
          end
        end
        ST_DATA: begin
          if (last_word) begin
            state <= ST_DONE;
          end else begin
            word_cnt <= word_cnt + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Early mode releases the indicator in the last delay cycle.
  assign wait_n     = !((state == ST_DELAY) && (!act_early || (dly_cnt != 4'd0)));
  assign data_valid = (state == ST_DATA);
  assign done       = (state == ST_DONE);

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [2:0]        wlog,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] wmask;
  logic [ADDR_W-1:0] addr_inc;
  logic [ADDR_W-1:0] addr_nxt;

  assign wmask    = ~({ADDR_W{1'b1}} << wlog);
  assign addr_inc = addr + ADDR_W'(1);
  assign addr_nxt = (addr & ~wmask) | (addr_inc & wmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_addr;
    end else if (step) begin
      addr <= addr_nxt;
    end
  end

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int MAX_WLOG = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              bus_x32,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              wait_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              data_valid,
  output logic              done
);

  seq_cfg_t   cfg_live;
  seq_state_t state;
  logic       idle;
  logic       start_accept;
  logic       last_word;
  logic [2:0] act_wlog;

  burst_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_we),
    .idle  (idle),
    .wdata (cfg_wdata),
    .cfg   (cfg_live),
    .rdata (cfg_rdata)
  );

  burst_ctrl #(.WC_W(MAX_WLOG)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .x32          (bus_x32),
    .cfg_live     (cfg_live),
    .state        (state),
    .idle         (idle),
    .start_accept (start_accept),
    .last_word    (last_word),
    .act_wlog     (act_wlog),
    .wait_n       (wait_n),
    .data_valid   (data_valid),
    .done         (done)
  );

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_accept),
    .step      (data_valid),
    .load_addr (start_addr),
    .wlog      (act_wlog),
    .addr      (mem_addr)
  );

endmodule

// File: rtl/burst_read_seq_chk.sv
module burst_read_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int MAX_WLOG = 5
) (
  input logic              clk,
  input logic              rst_n,
  input seq_state_t        state,
  input logic              start_accept,
  input logic              last_word,
  input logic              wait_n,
  input logic              data_valid,
  input logic              done,
  input logic [15:0]       cfg_rdata,
  input logic [ADDR_W-1:0] mem_addr
);

  a_r4_idle_wait_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> wait_n);

  a_r6_valid_not_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> wait_n);

  a_r3_accept_enters_delay: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> (!data_valid && !done));

  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> (done && !data_valid));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (state == ST_IDLE && !data_valid));

  a_r11_cfg_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(cfg_rdata));

  a_r8_window_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && $past(data_valid)) |-> $stable(mem_addr[ADDR_W-1:MAX_WLOG]));

  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_accept) |-> (cfg_rdata[7:6] == 2'b11 && cfg_rdata[5:3] == 3'd0));

endmodule

bind burst_read_seq burst_read_seq_chk #(.ADDR_W(ADDR_W), .MAX_WLOG(MAX_WLOG)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .state        (state),
  .start_accept (start_accept),
  .last_word    (last_word),
  .wait_n       (wait_n),
  .data_valid   (data_valid),
  .done         (done),
  .cfg_rdata    (cfg_rdata),
  .mem_addr     (mem_addr)
);

// File: tb/burst_read_seq_test.sv
module burst_read_seq_test;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic [15:0]   cfg_rdata;
  logic          bus_x32 = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          wait_n;
  logic [AW-1:0] mem_addr;
  logic          data_valid;
  logic          done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  burst_read_seq #(.ADDR_W(AW), .MAX_WLOG(5)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bus_x32(bus_x32), .start(start),
    .start_addr(start_addr), .wait_n(wait_n), .mem_addr(mem_addr),
    .data_valid(data_valid), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_lat(input int code);
    return (code >= 8) ? 9 : code + 2;
  endfunction

  function automatic bit exp_en(input int bl, input bit x32);
    return (bl >= 1 && bl <= 3) || (bl == 4 && !x32);
  endfunction

  function automatic int exp_words(input int bl, input bit x32);
    return (8 << (bl - 1)) / (x32 ? 4 : 2);
  endfunction

  function automatic logic [15:0] exp_rb(input logic [15:0] w);
    return (w & 16'h3D07) | 16'h00C0;
  endfunction

  task automatic run_burst(input int lat, input bit early, input int bl,
                           input bit x32, input int base, input bit disturb);
    logic [15:0] w;
    int L, N, off, win;
    w = 16'((lat << 10) | (int'(early) << 8) | bl);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_rdata == exp_rb(w), "R2", "readback", cfg_rdata, exp_rb(w));
    bus_x32 = x32; start = 1'b1; start_addr = AW'(base);
    @(negedge clk);
    start = 1'b0;
    if (!exp_en(bl, x32)) begin
      for (int m = 0; m < 4; m++) begin
        chk(wait_n && !data_valid && !done, "R7", "no burst",
            {wait_n, data_valid, done}, 3'b100);
        @(negedge clk);
      end
      return;
    end
    L = exp_lat(lat);
    N = exp_words(bl, x32);
    off = base % N;
    win = base - off;
    for (int m = 0; m <= L + N + 1; m++) begin
      bit ew, ev, ed;
      ew = early ? (m >= L - 1) : (m >= L);
      ev = (m >= L) && (m < L + N);
      ed = (m == L + N);
      chk(wait_n == ew, early ? "R5" : "R4", "wait_n", wait_n, ew);
      chk(data_valid == ev, (m == L) ? "R3" : "R6", "data_valid", data_valid, ev);
      chk(done == ed, (m == L + N + 1) ? "R10" : "R9", "done", done, ed);
      if (ev) begin
        int ea;
        ea = win + ((off + m - L) % N);
        chk(mem_addr == AW'(ea), "R8", "mem_addr", mem_addr, ea);
      end
      cfg_we = 1'b0; start = 1'b0;
      if (disturb && m == 1) begin
        cfg_we = 1'b1; cfg_wdata = ~w;
        start = 1'b1; start_addr = AW'(base + 5);
      end
      if (disturb && m == L + N) start = 1'b1;
      @(negedge clk);
    end
    cfg_we = 1'b0; start = 1'b0;
    chk(cfg_rdata == exp_rb(w), "R11", "cfg after busy write", cfg_rdata, exp_rb(w));
  endtask

  task automatic measure_lat(output int got);
    got = -1;
    for (int m = 0; m < 40; m++) begin
      if (data_valid && got < 0) got = m;
      if (done) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int got;
    repeat (3) @(negedge clk);
    chk(cfg_rdata == 16'h1CC4, "R1", "reset cfg", cfg_rdata, 16'h1CC4);
    chk(wait_n && !data_valid && !done, "R1", "reset outputs",
        {wait_n, data_valid, done}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reserved bits read fixed values whatever is written.
    cfg_we = 1'b1; cfg_wdata = 16'hFFFF;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_rdata == 16'h3DC7, "R2", "all-ones write", cfg_rdata, 16'h3DC7);

    // Full sweep over delay, wait mode, size code and bus width.
    for (int lat = 0; lat < 10; lat++) begin
      for (int e = 0; e < 2; e++) begin
        for (int bl = 0; bl < 8; bl++) begin
          for (int x = 0; x < 2; x++) begin
            int code, base;
            code = (lat == 9) ? 15 : lat;
            base = 'h12340 + lat * 7 + bl * 3 + x * 11 + e;
            run_burst(code, e[0], bl, x[0], base, ((lat + bl + x) % 2) == 1);
          end
        end
      end
    end

    // R11: write and start in the same cycle; old delay first, new one next.
    cfg_we = 1'b1; cfg_wdata = 16'h0001;
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 16'h1401;
    bus_x32 = 1'b0; start = 1'b1; start_addr = AW'(32);
    @(negedge clk);
    cfg_we = 1'b0; start = 1'b0;
    measure_lat(got);
    chk(got == 2, "R11", "same-cycle write latency", got, 2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    measure_lat(got);
    chk(got == 7, "R11", "next burst latency", got, 7);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule